// File: doc/BRIEF.md
# RTC Access Controller

This block holds a real-time clock and puts a small byte-wide register bus in front of it. The clock counts subseconds (256 per second), seconds, minutes, hours and a 16-bit day number. It advances on a tick-enable input, but only while the oscillator-enable bit is set. Software reaches the time registers through two timed windows. The read window exposes the time values. The write window lets the seconds-through-days fields be loaded and holds the clock still while that happens.

Each window opens when its enable bit is set and is usable for `WIN_CYC` cycles. The block clears the bit on its own after `AUTO_CLR_CYC` cycles. Any change of either enable bit starts a guard period of `GUARD_CYC` cycles. During that period time-register access and the setting of an enable bit are refused. The write-enable and oscillator-enable bits respond only to a control write issued in the cycle directly after a one-cycle `unlock_i` pulse.

Ticks that arrive while the write window holds the clock are counted in a small pending counter. When write-enable falls, the subsecond field is forced to zero and the pending ticks are then added one per cycle, so the elapsed count is kept.

Top module: `rtc_access_ctrl`

## Requirements
- R1: Address map: 0 control, 1 subsecond, 2 seconds, 3 minutes, 4 hours, 5 day low byte, 6 day high byte, 7 unused. A read of a time register returns 00h unless the read window is open. A read of address 7, or any read with `bus_rd_i` low, returns 00h.
- R2: A tick with the clock running advances subsecond. A field that is already at or above its limit (subsecond 255, seconds 59, minutes 59, hours 23) wraps to 0 and carries into the next field. The day count wraps modulo 65536.
- R3: While the oscillator-enable bit is 0, `tick_i` has no effect on the time.
- R4: The control register reads back {5'b0, read_en, write_en, osc_en} at any time. The read window is open while read_en is 1, no guard is active and fewer than `WIN_CYC` cycles have passed since read_en was set.
- R5: A write to addresses 2 to 6 is stored only while the write window is open (same rule as R4, applied to write_en). Writes to the subsecond register are always ignored.
- R6: While write_en is 1 the time does not advance. Each qualifying tick during that time adds one to a pending count, which saturates at 2^PEND_W-1. While the clock is running, one pending tick is applied in each cycle that has no new tick.
- R7: The edge on which write_en falls sets subsecond to 00h and keeps the pending count.
- R8: A control write with bit 2 and bit 1 both set is ignored entirely.
- R9: Every change of read_en or write_en starts a `GUARD_CYC`-cycle guard. During the guard, attempts to set either enable bit are ignored.
- R10: An enable bit that is still set `AUTO_CLR_CYC` cycles after it was set clears itself.
- R11: Bits 1 (write_en) and 0 (osc_en) change only on a control write in the cycle that follows an `unlock_i` pulse. Bit 2 (read_en) needs no unlock.
- R12: After reset the control register and all time fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Oscillator tick enable, one subsecond per pulse |
| unlock_i | input | 1 | Timed-access unlock pulse |
| bus_addr_i | input | 3 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational |

## Verification
The pending-tick drain and a fresh tick can fall in the same cycle after write_en falls. In that case the time advances by exactly one and the pending count is left unchanged. A second pair that can coincide is a software control write and the automatic expiry of the same window, since both act on the same edge. The bench ticks while the write window is held open and then releases it with ticks still flowing, and it lets windows expire while control writes are in flight. A behavioural model updated on every edge judges the read data in every cycle.

// File: rtl/rtc_acc_pkg.sv
package rtc_acc_pkg;

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_SUBSEC = 3'd1,
    A_SEC    = 3'd2,
    A_MIN    = 3'd3,
    A_HOUR   = 3'd4,
    A_DAY_LO = 3'd5,
    A_DAY_HI = 3'd6,
    A_NONE   = 3'd7
  } reg_addr_e;

  localparam int unsigned CB_OSC = 0;
  localparam int unsigned CB_WR  = 1;
  localparam int unsigned CB_RD  = 2;

  typedef struct packed {
    logic [15:0] day;
    logic [7:0]  hour;
    logic [7:0]  min;
    logic [7:0]  sec;
    logic [7:0]  ss;
  } rtc_time_t;

endpackage

// File: rtl/rtc_enable_win.sv
module rtc_enable_win #(
  parameter int unsigned CNT_W        = 8,
  parameter int unsigned WIN_CYC      = 20,
  parameter int unsigned AUTO_CLR_CYC = 39
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic en_o,
  output logic open_o,
  output logic toggle_o
);

  logic             en_q;
  logic [CNT_W-1:0] age_q;
  logic             expire;

  assign expire   = en_q && (age_q == CNT_W'(AUTO_CLR_CYC - 1));
  assign toggle_o = en_q ? (clr_i || expire) : set_i;
  assign en_o     = en_q;
  assign open_o   = en_q && (age_q < CNT_W'(WIN_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      age_q <= '0;
    end else if (toggle_o) begin
      en_q  <= ~en_q;
      age_q <= '0;
    end else if (en_q) begin
      age_q <= age_q + 1'b1;
    end
  end

endmodule

// File: rtl/rtc_guard.sv
module rtc_guard #(
  parameter int unsigned GUARD_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);

  localparam int unsigned GW = $clog2(GUARD_CYC + 1);

  logic [GW-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= GW'(GUARD_CYC);
    else if (busy_o) cnt_q <= cnt_q - 1'b1;
  end

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_acc_pkg::*;
#(
  parameter int unsigned PEND_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            halt_i,
  input  logic            clear_i,
  input  logic            wr_i,
  input  reg_addr_e       wr_addr_i,
  input  logic [7:0]      wr_data_i,
  output rtc_time_t       time_o,
  output logic [PEND_W-1:0] pend_o
);

  localparam logic [PEND_W-1:0] PMAX = {PEND_W{1'b1}};
  localparam logic [31:0]       LIMS = {8'd23, 8'd59, 8'd59, 8'd255};

  logic [PEND_W-1:0] pend_q;
  logic              adv;
  logic [4:0]        carry;
  logic [31:0]       fld_w;
  logic [15:0]       day_q;

  assign adv      = !halt_i && (tick_i || (pend_q != '0));
  assign carry[0] = adv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else if (halt_i) begin
      if (tick_i && (pend_q != PMAX)) pend_q <= pend_q + 1'b1;
    end else if (!tick_i && (pend_q != '0)) begin
      pend_q <= pend_q - 1'b1;
    end
  end

  for (genvar i = 0; i < 4; i++) begin : g_fld
    localparam logic [7:0] LIM = LIMS[i*8 +: 8];
    logic [7:0] val_q;
    logic       wrap;
    logic       wr_hit;
    logic       clr_hit;

    assign wrap       = (val_q >= LIM);
    assign carry[i+1] = carry[i] && wrap;
    assign fld_w[i*8 +: 8] = val_q;

    if (i == 0) begin : g_ss
      assign wr_hit  = 1'b0;
      assign clr_hit = clear_i;
    end else begin : g_rw
      assign wr_hit  = wr_i && (wr_addr_i == reg_addr_e'(3'(i + 1)));
      assign clr_hit = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       val_q <= '0;
      else if (clr_hit)  val_q <= '0;
      else if (wr_hit)   val_q <= wr_data_i;
      else if (carry[i]) val_q <= wrap ? 8'd0 : val_q + 8'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              day_q <= '0;
    else if (wr_i && wr_addr_i == A_DAY_LO)   day_q[7:0]  <= wr_data_i;
    else if (wr_i && wr_addr_i == A_DAY_HI)   day_q[15:8] <= wr_data_i;
    else if (carry[4])                        day_q <= day_q + 16'd1;
  end

  assign time_o.ss   = fld_w[7:0];
  assign time_o.sec  = fld_w[15:8];
  assign time_o.min  = fld_w[23:16];
  assign time_o.hour = fld_w[31:24];
  assign time_o.day  = day_q;
  assign pend_o      = pend_q;

endmodule

// File: rtl/rtc_access_ctrl.sv
module rtc_access_ctrl
  import rtc_acc_pkg::*;
#(
  parameter int unsigned GUARD_CYC    = 4,
  parameter int unsigned WIN_CYC      = 125000,
  parameter int unsigned AUTO_CLR_CYC = 243750,
  parameter int unsigned PEND_W       = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       unlock_i,
  input  logic [2:0] bus_addr_i,
  input  logic       bus_wr_i,
  input  logic       bus_rd_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o
);

  localparam int unsigned CNT_W = $clog2(AUTO_CLR_CYC + 1);

  reg_addr_e         addr;
  logic              unlock_q;
  logic              osc_q;
  logic              guard_busy;
  logic [1:0]        win_set, win_clr, win_en, win_open, win_tgl;
  logic              ctrl_wr;
  logic              rd_en, wr_en, rd_ok, wr_ok, wr_fall;
  rtc_time_t         tm;
  logic [7:0]        ss_cur;
  logic [PEND_W-1:0] pend_cnt;

  assign addr    = reg_addr_e'(bus_addr_i);
  assign ctrl_wr = bus_wr_i && (addr == A_CTRL) &&
                   !(bus_wdata_i[CB_RD] && bus_wdata_i[CB_WR]);

  // index 0: read window, index 1: write window
  always_comb begin
    win_set[0] = ctrl_wr && bus_wdata_i[CB_RD] && !guard_busy;
    win_clr[0] = ctrl_wr && !bus_wdata_i[CB_RD];
    win_set[1] = ctrl_wr && unlock_q && bus_wdata_i[CB_WR] && !guard_busy;
    win_clr[1] = ctrl_wr && unlock_q && !bus_wdata_i[CB_WR];
  end

  for (genvar w = 0; w < 2; w++) begin : g_win
    rtc_enable_win #(
      .CNT_W       (CNT_W),
      .WIN_CYC     (WIN_CYC),
      .AUTO_CLR_CYC(AUTO_CLR_CYC)
    ) i_win (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (win_set[w]),
      .clr_i   (win_clr[w]),
      .en_o    (win_en[w]),
      .open_o  (win_open[w]),
      .toggle_o(win_tgl[w])
    );
  end

  rtc_guard #(.GUARD_CYC(GUARD_CYC)) i_guard (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(|win_tgl),
    .busy_o(guard_busy)
  );

  assign rd_en   = win_en[0];
  assign wr_en   = win_en[1];
  assign rd_ok   = win_open[0] && !guard_busy;
  assign wr_ok   = win_open[1] && !guard_busy;
  assign wr_fall = win_tgl[1] && wr_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlock_q <= 1'b0;
      osc_q    <= 1'b0;
    end else begin
      unlock_q <= unlock_i;
      if (ctrl_wr && unlock_q) osc_q <= bus_wdata_i[CB_OSC];
    end
  end

  rtc_time_core #(.PEND_W(PEND_W)) i_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i && osc_q),
    .halt_i   (wr_en),
    .clear_i  (wr_fall),
    .wr_i     (bus_wr_i && wr_ok),
    .wr_addr_i(addr),
    .wr_data_i(bus_wdata_i),
    .time_o   (tm),
    .pend_o   (pend_cnt)
  );

  assign ss_cur = tm.ss;

  always_comb begin
    bus_rdata_o = 8'h00;
    if (bus_rd_i) begin
      unique case (addr)
        A_CTRL:   bus_rdata_o = {5'b0, rd_en, wr_en, osc_q};
        A_SUBSEC: bus_rdata_o = rd_ok ? tm.ss       : 8'h00;
        A_SEC:    bus_rdata_o = rd_ok ? tm.sec      : 8'h00;
        A_MIN:    bus_rdata_o = rd_ok ? tm.min      : 8'h00;
        A_HOUR:   bus_rdata_o = rd_ok ? tm.hour     : 8'h00;
        A_DAY_LO: bus_rdata_o = rd_ok ? tm.day[7:0] : 8'h00;
        A_DAY_HI: bus_rdata_o = rd_ok ? tm.day[15:8]: 8'h00;
        default:  bus_rdata_o = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/rtc_access_chk.sv
module rtc_access_chk #(
  parameter int unsigned AUTO_CLR_CYC = 39,
  parameter int unsigned PEND_W       = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              unlock_q,
  input logic              osc_en,
  input logic              rd_en,
  input logic              wr_en,
  input logic              wr_fall,
  input logic              guard_busy,
  input logic [7:0]        ss,
  input logic [PEND_W-1:0] pend
);

  logic [31:0] rd_run, wr_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_run <= '0;
      wr_run <= '0;
    end else begin
      rd_run <= rd_en ? rd_run + 32'd1 : 32'd0;
      wr_run <= wr_en ? wr_run + 32'd1 : 32'd0;
    end
  end

  AST_HALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && !wr_fall) |=> $stable(ss)); // R6
  AST_FALL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fall |=> (ss == 8'h00)); // R7
  AST_OSC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_en && (pend == '0) && !wr_fall) |=> $stable(ss)); // R3
  AST_GUARD_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en != $past(rd_en)) |-> guard_busy); // R9
  AST_GUARD_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en != $past(wr_en)) |-> guard_busy); // R9
  AST_OSC_UNLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_en != $past(osc_en)) |-> $past(unlock_q)); // R11
  AST_WR_UNLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_en) |-> $past(unlock_q)); // R11
  AST_RD_LIFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en |-> (rd_run < AUTO_CLR_CYC)); // R10
  AST_WR_LIFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (wr_run < AUTO_CLR_CYC)); // R10

endmodule

bind rtc_access_ctrl rtc_access_chk #(
  .AUTO_CLR_CYC(AUTO_CLR_CYC),
  .PEND_W      (PEND_W)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .unlock_q  (unlock_q),
  .osc_en    (osc_q),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .wr_fall   (wr_fall),
  .guard_busy(guard_busy),
  .ss        (ss_cur),
  .pend      (pend_cnt)
);

// File: tb/test_rtc_access_ctrl.sv
module test_rtc_access_ctrl;

  localparam int G = 4;
  localparam int W = 20;
  localparam int A = 39;
  localparam int P = 3;
  localparam int PMAX = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       unl = 1'b0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rdata;

  int total = 0;
  int bad = 0;
  string cur_req = "R12";

  always #4 clk = ~clk;

  rtc_access_ctrl #(
    .GUARD_CYC(G), .WIN_CYC(W), .AUTO_CLR_CYC(A), .PEND_W(P)
  ) i_rtc_access_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .unlock_i(unl),
    .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wd), .bus_rdata_o(rdata)
  );

  // behavioural reference model
  int m_osc, m_rd, m_wr, m_rage, m_wage, m_guard, m_unl;
  int m_ss, m_sec, m_min, m_hour, m_day, m_pend;

  task automatic m_reset();
    m_osc = 0; m_rd = 0; m_wr = 0; m_rage = 0; m_wage = 0; m_guard = 0;
    m_unl = 0; m_ss = 0; m_sec = 0; m_min = 0; m_hour = 0; m_day = 0;
    m_pend = 0;
  endtask

  task automatic m_advance();
    if (m_ss >= 255) begin
      m_ss = 0;
      if (m_sec >= 59) begin
        m_sec = 0;
        if (m_min >= 59) begin
          m_min = 0;
          if (m_hour >= 23) begin
            m_hour = 0;
            m_day = (m_day + 1) % 65536;
          end else m_hour++;
        end else m_min++;
      end else m_sec++;
    end else m_ss++;
  endtask

  function automatic logic [7:0] m_rdata();
    int ok;
    ok = (m_rd != 0) && (m_rage < W) && (m_guard == 0);
    if (!rd) return 8'h00;
    case (addr)
      3'd0: return {5'b0, m_rd[0], m_wr[0], m_osc[0]};
      3'd1: return ok ? m_ss[7:0] : 8'h00;
      3'd2: return ok ? m_sec[7:0] : 8'h00;
      3'd3: return ok ? m_min[7:0] : 8'h00;
      3'd4: return ok ? m_hour[7:0] : 8'h00;
      3'd5: return ok ? m_day[7:0] : 8'h00;
      3'd6: return ok ? m_day[15:8] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_step();
    int busy, cw, rs, rc, ws, wc, rt, wt, wok, wf, tv;
    busy = (m_guard != 0);
    cw = wr && (addr == 3'd0) && !(wd[2] && wd[1]);
    rs = cw && wd[2] && !busy;
    rc = cw && !wd[2];
    ws = cw && (m_unl != 0) && wd[1] && !busy;
    wc = cw && (m_unl != 0) && !wd[1];
    rt = (m_rd != 0) ? (rc || (m_rage == A - 1)) : rs;
    wt = (m_wr != 0) ? (wc || (m_wage == A - 1)) : ws;
    wok = (m_wr != 0) && (m_wage < W) && !busy;
    wf = wt && (m_wr != 0);
    tv = tick && (m_osc != 0);
    if (m_wr == 0) begin
      if (tv || m_pend > 0) m_advance();
      if (!tv && m_pend > 0) m_pend--;
    end else if (tv && m_pend < PMAX) m_pend++;
    if (wr && wok) begin
      case (addr)
        3'd2: m_sec = wd;
        3'd3: m_min = wd;
        3'd4: m_hour = wd;
        3'd5: m_day = (m_day & 16'hFF00) | wd;
        3'd6: m_day = (m_day & 16'h00FF) | (int'(wd) << 8);
        default: ;
      endcase
    end
    if (wf) m_ss = 0;
    if (cw && (m_unl != 0)) m_osc = wd[0];
    if (rt) begin m_rd = !m_rd; m_rage = 0; end else if (m_rd != 0) m_rage++;
    if (wt) begin m_wr = !m_wr; m_wage = 0; end else if (m_wr != 0) m_wage++;
    if (rt || wt) m_guard = G; else if (m_guard > 0) m_guard--;
    m_unl = unl;
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else m_step();
  end

  // per-cycle comparison, just before the rising edge
  always @(negedge clk) begin
    logic [7:0] e;
    #3;
    if (rst_n) begin
      e = m_rdata();
      total++;
      if (rdata !== e) begin
        bad++;
        $display("FAIL %s cycle compare addr=%0d actual=%02h expected=%02h",
                 cur_req, addr, rdata, e);
      end
    end
  end

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", r, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr = 1'b1; wd = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic unlock_write(input logic [7:0] d);
    @(negedge clk); unl = 1'b1;
    @(negedge clk); unl = 1'b0; addr = 3'd0; wr = 1'b1; wd = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); addr = a;
    #2; v = rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic open_rd();
    bus_write(3'd0, 8'h00);
    idle(6);
    bus_write(3'd0, 8'h04);
    idle(6);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    rd = 1'b1;
    idle(3);
    rst_n = 1'b1;

    cur_req = "R12";
    peek(3'd0, v); chk("R12", v, 8'h00);
    peek(3'd7, v); chk("R1", v, 8'h00);

    cur_req = "R3";
    ticks(10);
    bus_write(3'd0, 8'h04);
    idle(6);
    peek(3'd1, v); chk("R3", v, 8'h00);

    cur_req = "R11";
    bus_write(3'd0, 8'h05);
    peek(3'd0, v); chk("R11", v, 8'h04);
    unlock_write(8'h05);
    peek(3'd0, v); chk("R11", v, 8'h05);

    cur_req = "R2";
    ticks(300);
    open_rd();
    peek(3'd1, v); chk("R2", v, 8'd44);
    peek(3'd2, v); chk("R2", v, 8'd1);

    cur_req = "R5";
    bus_write(3'd2, 8'd30);
    peek(3'd2, v); chk("R5", v, 8'd1);

    cur_req = "R6";
    unlock_write(8'h03);
    ticks(3);
    idle(3);
    bus_write(3'd2, 8'd59);
    bus_write(3'd3, 8'd59);
    bus_write(3'd4, 8'd23);
    bus_write(3'd5, 8'hFF);
    bus_write(3'd6, 8'hFF);
    bus_write(3'd1, 8'h10);
    bus_write(3'd0, 8'h04);
    idle(5);
    peek(3'd1, v); chk("R6", v, 8'd44);
    peek(3'd5, v); chk("R5", v, 8'hFF);
    peek(3'd4, v); chk("R5", v, 8'd23);

    cur_req = "R7";
    unlock_write(8'h05);
    idle(5);
    open_rd();
    peek(3'd1, v); chk("R7", v, 8'd3);

    cur_req = "R2";
    ticks(256);
    open_rd();
    peek(3'd1, v); chk("R2", v, 8'd3);
    peek(3'd2, v); chk("R2", v, 8'd0);
    peek(3'd4, v); chk("R2", v, 8'd0);
    peek(3'd6, v); chk("R2", v, 8'd0);

    cur_req = "R8";
    unlock_write(8'h07);
    peek(3'd0, v); chk("R8", v, 8'h05);

    cur_req = "R9";
    bus_write(3'd0, 8'h00);
    bus_write(3'd0, 8'h04);
    idle(6);
    peek(3'd0, v); chk("R9", v, 8'h01);
    bus_write(3'd0, 8'h04);
    peek(3'd1, v); chk("R9", v, 8'h00);
    idle(5);
    peek(3'd1, v); chk("R4", v, 8'd3);

    cur_req = "R4";
    idle(15);
    peek(3'd0, v); chk("R4", v, 8'h05);
    peek(3'd1, v); chk("R4", v, 8'h00);

    cur_req = "R10";
    idle(20);
    peek(3'd0, v); chk("R10", v, 8'h01);

    cur_req = "R3";
    unlock_write(8'h00);
    ticks(20);
    open_rd();
    peek(3'd1, v); chk("R3", v, 8'd3);

    idle(2);
    finish_run();
  end

endmodule